// File: doc/BRIEF.md
# Keyboard Interface Controller

This block sits on the host side of a simple keyboard link. It receives scan codes that arrive already assembled as whole bytes, holds one of them for the processor, and raises an interrupt request while a byte is waiting. A read strobe hands the byte over, empties the holding register and drops the request.

A 2-bit mode, written through a strobe from the upper bits of a system control port, selects how the block treats incoming bytes and its request line. One mode receives bytes normally. One mode discards incoming bytes and drops the request. The other two modes start a keyboard reset. One of these drops the request, and the other leaves the request as it is. After a reset starts, a countdown advances on a tick-enable pulse. When the countdown runs out, the self-test completion byte 0xAA is posted and the request is raised, just as if the keyboard had sent it.

Top module: `kbi_ctrl`

## Requirements
- R1: After reset (rst_ni low), data_o is 0x00 and irq_o is 0. The mode is normal (2'b01), and no countdown is pending, so any number of tick_i pulses posts nothing.
- R2: In mode 2'b01, code_valid_i with an empty holding register latches code_i. data_o shows the byte and irq_o is 1 from the next clock edge. A received 0x00 also raises irq_o.
- R3: Writing mode 2'b11 drives irq_o to 0 on the next edge. In any mode other than 2'b01, bytes on code_valid_i are discarded and data_o does not change.
- R4: Writing mode 2'b10 drives irq_o to 0 on the next edge and starts a reset countdown of RESET_TICKS (default 5) ticks.
- R5: Writing mode 2'b00 starts the same countdown and leaves irq_o unchanged, so a request that is already high stays high.
- R6: On the edge of the RESET_TICKS-th tick_i pulse after a reset mode write, data_o becomes 0xAA and irq_o becomes 1. This overwrites any held byte. After one tick fewer, nothing has been posted.
- R7: The countdown advances only on edges where tick_i is 1. Cycles without tick_i do not move it.
- R8: While rd_i is 1, data_o presents the held byte. After that edge, data_o is 0x00 and irq_o is 0. A read of an empty register returns 0x00.
- R9: A byte that arrives while a byte is held and not yet read is dropped, and the held byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode write strobe |
| mode_i | input | 2 | Mode value written on mode_we_i |
| code_valid_i | input | 1 | Scan code byte valid strobe |
| code_i | input | 8 | Assembled scan code byte |
| rd_i | input | 1 | Read strobe for the held byte |
| tick_i | input | 1 | Countdown tick enable |
| data_o | output | 8 | Held byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Every result is registered once. A byte, a mode write, a read or the final tick shows its effect on data_o and irq_o right after the next rising edge, and read data is valid during the cycle in which rd_i is high. The bench drives each strobe for one cycle starting at a falling edge and samples at the following falling edge, half a period after the edge that commits the result. For the countdown, it applies one tick fewer than needed and checks that nothing has been posted. It then runs idle cycles to show that the count holds, and applies the last tick to see 0xAA appear after that edge.

// File: rtl/kbi_pkg.sv
package kbi_pkg;
  typedef enum logic [1:0] {
    KB_RST_HOLD = 2'b00,  // reset keyboard, request untouched
    KB_NORMAL   = 2'b01,
    KB_RST_CLR  = 2'b10,  // reset keyboard, request dropped
    KB_QUIET    = 2'b11
  } kb_mode_e;
endpackage

// File: rtl/kbi_mode_reg.sv
module kbi_mode_reg
  import kbi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [1:0] mode_i,
  output kb_mode_e   mode_o,
  output logic       clr_irq_o,
  output logic       start_rst_o
);
  kb_mode_e mode_q;
  kb_mode_e mode_new;

  assign mode_new = kb_mode_e'(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= KB_NORMAL;
    else if (mode_we_i) mode_q <= mode_new;
  end

  always_comb begin
    clr_irq_o   = 1'b0;
    start_rst_o = 1'b0;
    if (mode_we_i) begin
      unique case (mode_new)
        KB_QUIET:    clr_irq_o = 1'b1;
        KB_RST_CLR:  begin clr_irq_o = 1'b1; start_rst_o = 1'b1; end
        KB_RST_HOLD: start_rst_o = 1'b1;
        default:     ;
      endcase
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/kbi_reset_timer.sv
module kbi_reset_timer #(
  parameter int RESET_TICKS = 5,
  localparam int CNT_W = $clog2(RESET_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             post_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (start_i)                 cnt_q <= CNT_W'(RESET_TICKS);
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // fires on the edge that takes the count from one to zero
  assign post_o = tick_i && !start_i && (cnt_q == CNT_W'(1));
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/kbi_data_reg.sv
module kbi_data_reg #(
  parameter int               DATA_W   = 8,
  parameter logic [DATA_W-1:0] POST_CODE = 8'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              rd_i,
  input  logic              post_i,
  input  logic              clr_irq_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, irq_q;

  // priority: self-test post, read, receive, mode clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (post_i) begin
      data_q <= POST_CODE;
      full_q <= 1'b1;
      irq_q  <= 1'b1;
    end else if (rd_i) begin
      data_q <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (rx_en_i && !full_q) begin
      data_q <= code_i;
      full_q <= 1'b1;
      irq_q  <= !clr_irq_i;
    end else if (clr_irq_i) begin
      irq_q  <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/kbi_ctrl.sv
module kbi_ctrl
  import kbi_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               RESET_TICKS = 5,
  parameter logic [DATA_W-1:0] POST_CODE  = 8'hAA,
  localparam int CNT_W = $clog2(RESET_TICKS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [1:0]        mode_i,
  input  logic              code_valid_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              rd_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] data_o,
  output logic              irq_o
);
  kb_mode_e         mode_q;
  logic             clr_irq, start_rst, post_w, full_w;
  logic [CNT_W-1:0] tmr_cnt;

  kbi_mode_reg u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .mode_o(mode_q), .clr_irq_o(clr_irq), .start_rst_o(start_rst)
  );

  kbi_reset_timer #(.RESET_TICKS(RESET_TICKS)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_rst), .tick_i(tick_i),
    .cnt_o(tmr_cnt), .post_o(post_w)
  );

  kbi_data_reg #(.DATA_W(DATA_W), .POST_CODE(POST_CODE)) u_data (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rx_en_i(code_valid_i && mode_q == KB_NORMAL), .code_i(code_i),
    .rd_i(rd_i), .post_i(post_w), .clr_irq_i(clr_irq),
    .data_o(data_o), .full_o(full_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/kbi_ctrl_chk.sv
module kbi_ctrl_chk #(
  parameter int               DATA_W      = 8,
  parameter int               RESET_TICKS = 5,
  parameter logic [DATA_W-1:0] POST_CODE  = 8'hAA,
  localparam int CNT_W = $clog2(RESET_TICKS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_we_i,
  input logic [1:0]        mode_i,
  input logic              code_valid_i,
  input logic [DATA_W-1:0] code_i,
  input logic              rd_i,
  input logic              tick_i,
  input logic [DATA_W-1:0] data_o,
  input logic              irq_o,
  input logic [1:0]        mode_q,
  input logic              full_w,
  input logic              post_w,
  input logic [CNT_W-1:0]  tmr_cnt
);
  a_r1_idle_no_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_cnt == '0 |-> !post_w);

  a_r2_receive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == 2'b01 && code_valid_i && !full_w && !rd_i && !post_w && !mode_we_i
    |=> data_o == $past(code_i) && irq_o);

  a_r3_quiet_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && mode_i == 2'b11 && !post_w |=> !irq_o);

  a_r4_clr_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && mode_i == 2'b10 |=> !irq_o && tmr_cnt == CNT_W'(RESET_TICKS));

  a_r5_irq_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_we_i && mode_i == 2'b00 && irq_o && !rd_i |=> irq_o);

  a_r6_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_w |=> data_o == POST_CODE && irq_o);

  a_r7_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !mode_we_i |=> $stable(tmr_cnt));

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !post_w |=> data_o == '0 && !irq_o);

  a_r9_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_w && code_valid_i && !rd_i && !post_w |=> $stable(data_o));
endmodule

bind kbi_ctrl kbi_ctrl_chk #(
  .DATA_W(DATA_W), .RESET_TICKS(RESET_TICKS), .POST_CODE(POST_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
  .code_valid_i(code_valid_i), .code_i(code_i), .rd_i(rd_i), .tick_i(tick_i),
  .data_o(data_o), .irq_o(irq_o), .mode_q(mode_q), .full_w(full_w),
  .post_w(post_w), .tmr_cnt(tmr_cnt)
);

// File: tb/kbi_ctrl_tb.sv
module kbi_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic       code_valid_i = 1'b0;
  logic [7:0] code_i = '0;
  logic       rd_i = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] data_o;
  logic       irq_o;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] rd_val;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  kbi_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .code_valid_i(code_valid_i), .code_i(code_i), .rd_i(rd_i), .tick_i(tick_i),
    .data_o(data_o), .irq_o(irq_o)
  );

  // {mode, code, expected data, expected irq}
  localparam logic [18:0] VEC [6] = '{
    {2'b01, 8'h5A, 8'h5A, 1'b1},
    {2'b01, 8'hF0, 8'hF0, 1'b1},
    {2'b11, 8'h77, 8'h00, 1'b0},
    {2'b01, 8'hE1, 8'hE1, 1'b1},
    {2'b10, 8'h3C, 8'h00, 1'b0},
    {2'b01, 8'h00, 8'h00, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] m);
    mode_i = m; mode_we_i = 1'b1;
    @(negedge clk_i); mode_we_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] c);
    code_i = c; code_valid_i = 1'b1;
    @(negedge clk_i); code_valid_i = 1'b0;
  endtask

  task automatic do_read();
    rd_i = 1'b1; rd_val = data_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1; @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic reset_dut();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    reset_dut();
    // R1 reset state, no post from idle ticks
    check("R1 data", data_o, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h01 & 8'h00);
    ticks(10);
    check("R1 no post", {7'b0, irq_o}, 8'h00);

    // table: R2 receive, R3 discard in non-normal modes, R8 read clears
    for (int i = 0; i < 6; i++) begin
      write_mode(VEC[i][18:17]);
      send(VEC[i][16:9]);
      check("R2/R3 data", data_o, VEC[i][8:1]);
      check("R2/R3 irq", {7'b0, irq_o}, {7'b0, VEC[i][0]});
      do_read();
      check("R8 read value", rd_val, VEC[i][8:1]);
      check("R8 cleared", {irq_o, data_o[6:0]}, 8'h00);
    end
    reset_dut();

    // R8 empty read
    do_read();
    check("R8 empty read", rd_val, 8'h00);

    // R9 drop while full
    send(8'h1C);
    send(8'h2D);
    check("R9 held kept", data_o, 8'h1C);

    // R5 mode 00 keeps irq, R6 countdown
    write_mode(2'b00);
    check("R5 irq kept", {7'b0, irq_o}, 8'h01);
    check("R5 data kept", data_o, 8'h1C);
    ticks(4);
    check("R6 not yet", data_o, 8'h1C);
    ticks(1);
    check("R6 post data", data_o, 8'hAA);
    check("R6 post irq", {7'b0, irq_o}, 8'h01);

    // R4 mode 10 drops irq, R7 idle cycles hold count
    write_mode(2'b10);
    check("R4 irq low", {7'b0, irq_o}, 8'h00);
    do_read();
    ticks(4);
    repeat (20) @(negedge clk_i);
    check("R7 held", {irq_o, data_o[6:0]}, 8'h00);
    ticks(1);
    check("R7 post after last tick", data_o, 8'hAA);
    send(8'h55);
    check("R3 discard in reset mode", data_o, 8'hAA);
    do_read();
    check("R8 post read", rd_val, 8'hAA);

    // R3 quiet mode drops irq, keeps byte, discards new
    write_mode(2'b01);
    send(8'h33);
    write_mode(2'b11);
    check("R3 irq low", {7'b0, irq_o}, 8'h00);
    do_read();
    send(8'h44);
    check("R3 discard", data_o, 8'h00);
    check("R3 read old", rd_val, 8'h33);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule